// File: doc/BRIEF.md
# Bridge Interrupt Message Aggregator

This block sits beside a bus bridge and collects up to eleven device interrupt lines into one processor interrupt. It does not drive a wire to the processor. It sends a single posted write, a message, whose address and data word software programs in advance. Each input line is brought into the clock domain and checked for a rising edge. An edge on an enabled line sets a sticky pending bit and asks for a message.

Software reaches the block through a simple 32-bit register port. The combinational read data and the side effects of a read land on the clock edge that ends the access. Two read-to-clear views of the pending bits sit next to a live-level view of the lines. This lets an interrupt handler notice a line that is still asserted after it acknowledged the edge, and so treat the inputs as level-sensitive. A write of the programmed data value to the acknowledge offset sends a message on demand, which recovers a level that no edge reported.

Top module: `irq_msg_aggregator`

## Requirements
- R1: After reset, the enable, pending, target and control registers read as zero and `msg_valid` is low.
- R2: Offset 0x028 returns the synchronised line levels (bit i = line i), delayed by two clocks from the input pins. Reading it does not change the pending bits.
- R3: A rising edge on line i while enable bit i (offset 0x018) is set sets pending bit i. An edge on a disabled line sets nothing.
- R4: A read of offset 0x00C returns the pending bits and clears them. An edge that sets a pending bit on the same clock as the clearing read is kept.
- R5: A read of offset 0x01C also returns the pending bits and clears them.
- R6: Line 9 is unimplemented (implemented mask 0x5FF). It never sets a pending bit and never causes a message.
- R7: An enabled edge raises `msg_valid`. The message carries `msg_addr` = target with bits 4:0 cleared and `msg_data` = target bits 4:0, zero-extended.
- R8: `msg_valid` stays high until `msg_ready` is seen. Events that occur while a message waits merge into it. An event on the clock that accepts a message produces one further message.
- R9: A line that is already high when its enable bit is set produces neither a pending bit nor a message.
- R10: A write to offset 0x00C whose bits 4:0 equal target bits 4:0 forces a message. A write with any other value there sends nothing.
- R11: Target (0x004, 32 bits), enable (0x018, 11 bits) and control (0x024, 8 bits) read back what was written. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 11 | Asynchronous device interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects apply at the clock edge) |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the current offset |
| msg_valid | output | 1 | Message write request |
| msg_ready | input | 1 | Message accepted when high together with valid |
| msg_addr | output | 32 | Message target address |
| msg_data | output | 32 | Message data word |

## Verification
On every cycle the assertions check three things. A waiting message stays valid until it is accepted. A new message always has a trigger in the cycle before it. A pending bit never appears on a line that was disabled in the previous cycle, and a clearing read with no coincident edge leaves nothing pending. Only the bench scenarios can show the rest: merging and re-arming of messages, the edge that races a clearing read, the silence of an already-high line when it is enabled, the forced-message match on the data field, and the absence of any effect from line 9. The bench compares the message port each cycle against a behavioural model built on a history queue of the inputs.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int DEF_NLINES    = 11;
    localparam int DEF_REG_AW    = 12;
    localparam int DEF_DATA_BITS = 5;
    localparam int DEF_CTRL_W    = 8;
    localparam int WORD_W        = 32;

    localparam logic [DEF_NLINES-1:0] DEF_IMPL_MASK = 11'h5FF;

    localparam logic [DEF_REG_AW-1:0] OFS_TARGET = 12'h004;
    localparam logic [DEF_REG_AW-1:0] OFS_ACK    = 12'h00C;
    localparam logic [DEF_REG_AW-1:0] OFS_ENABLE = 12'h018;
    localparam logic [DEF_REG_AW-1:0] OFS_STAT   = 12'h01C;
    localparam logic [DEF_REG_AW-1:0] OFS_CTRL   = 12'h024;
    localparam logic [DEF_REG_AW-1:0] OFS_LEVEL  = 12'h028;
endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] old;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.s1  = lines_i;
        st_d.s2  = st_q.s1;
        st_d.old = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_line
        assign rise_o[g] = st_q.s2[g] & ~st_q.old[g];
    end

    assign level_o = st_q.s2;

    AST_RISE_FOLLOWS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rise_o & $past(level_o)) == '0)); // R3
endmodule

// File: rtl/irq_msg_port.sv
module irq_msg_port #(
    parameter int AW        = 32,
    parameter int DATA_BITS = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_i,
    input  logic [AW-1:0] target_i,
    output logic          msg_valid_o,
    input  logic          msg_ready_i,
    output logic [AW-1:0] msg_addr_o,
    output logic [AW-1:0] msg_data_o
);
    localparam logic [AW-1:0] DATA_MASK = AW'((1 << DATA_BITS) - 1);

    typedef struct packed {
        logic send;
    } port_t;

    port_t p_d, p_q;

    always_comb begin
        p_d      = p_q;
        p_d.send = (p_q.send & ~msg_ready_i) | trig_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign msg_valid_o = p_q.send;
    assign msg_addr_o  = target_i & ~DATA_MASK;
    assign msg_data_o  = target_i & DATA_MASK;

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid_o && !msg_ready_i) |=> msg_valid_o); // R8
    AST_MSG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid_o) |-> $past(trig_i)); // R7
endmodule

// File: rtl/irq_msg_aggregator.sv
module irq_msg_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NLINES    = DEF_NLINES,
    parameter int REG_AW    = DEF_REG_AW,
    parameter int DATA_BITS = DEF_DATA_BITS,
    parameter int CTRL_W    = DEF_CTRL_W,
    parameter logic [NLINES-1:0] IMPL_MASK = DEF_IMPL_MASK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irq_lines,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [WORD_W-1:0] msg_addr,
    output logic [WORD_W-1:0] msg_data
);
    localparam int LINE_PAD = WORD_W - NLINES;
    localparam int CTRL_PAD = WORD_W - CTRL_W;

    typedef struct packed {
        logic [WORD_W-1:0] target;
        logic [NLINES-1:0] en;
        logic [NLINES-1:0] pend;
        logic [CTRL_W-1:0] ctrl;
    } regs_t;

    regs_t r_d, r_q;

    logic [NLINES-1:0] level, rise, hit;
    logic              clr_rd, force_wr, trig;

    irq_line_sync #(.N(NLINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (irq_lines),
        .level_o (level),
        .rise_o  (rise)
    );

    always_comb begin
        r_d      = r_q;
        hit      = rise & r_q.en & IMPL_MASK;
        clr_rd   = reg_rd && (reg_addr == OFS_ACK || reg_addr == OFS_STAT);
        force_wr = reg_wr && (reg_addr == OFS_ACK)
                   && (reg_wdata[DATA_BITS-1:0] == r_q.target[DATA_BITS-1:0]);
        trig     = (|hit) | force_wr;

        r_d.pend = (clr_rd ? '0 : r_q.pend) | hit;

        if (reg_wr) begin
            case (reg_addr)
                OFS_TARGET: r_d.target = reg_wdata;
                OFS_ENABLE: r_d.en     = reg_wdata[NLINES-1:0];
                OFS_CTRL:   r_d.ctrl   = reg_wdata[CTRL_W-1:0];
                default: ;
            endcase
        end

        case (reg_addr)
            OFS_TARGET:         reg_rdata = r_q.target;
            OFS_ACK, OFS_STAT:  reg_rdata = {{LINE_PAD{1'b0}}, r_q.pend};
            OFS_ENABLE:         reg_rdata = {{LINE_PAD{1'b0}}, r_q.en};
            OFS_CTRL:           reg_rdata = {{CTRL_PAD{1'b0}}, r_q.ctrl};
            OFS_LEVEL:          reg_rdata = {{LINE_PAD{1'b0}}, level};
            default:            reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    irq_msg_port #(.AW(WORD_W), .DATA_BITS(DATA_BITS)) u_msg (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_i      (trig),
        .target_i    (r_q.target),
        .msg_valid_o (msg_valid),
        .msg_ready_i (msg_ready),
        .msg_addr_o  (msg_addr),
        .msg_data_o  (msg_data)
    );

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFS_ACK && (rise & r_q.en) == '0) |=> (r_q.pend == '0)); // R4
    AST_STAT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFS_STAT && (rise & r_q.en) == '0) |=> (r_q.pend == '0)); // R5
    AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((r_q.pend & ~$past(r_q.pend) & ~$past(r_q.en)) == '0)); // R3
endmodule

// File: tb/tb_irq_msg_aggregator.sv
module tb_irq_msg_aggregator;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [10:0] irq_lines;
    logic        reg_wr, reg_rd;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        msg_valid, msg_ready;
    logic [31:0] msg_addr, msg_data;

    int n_chk = 0;
    int n_err = 0;
    int wd    = 0;

    irq_msg_aggregator dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    logic [10:0] hq[$];
    logic [10:0] m_en, m_pend;
    logic [31:0] m_target;
    logic        m_send;

    always @(posedge clk) begin
        logic [10:0] rise_m, hit_m;
        logic        trig_m, clr_m;
        if (!rst_n) begin
            hq = '{11'h0, 11'h0, 11'h0};
            m_en = '0; m_pend = '0; m_target = '0; m_send = 1'b0;
        end else begin
            rise_m = hq[1] & ~hq[2];
            hit_m  = rise_m & m_en & 11'h5FF;
            trig_m = (hit_m != 0) ||
                     (reg_wr && reg_addr == 12'h00C && reg_wdata[4:0] == m_target[4:0]);
            clr_m  = reg_rd && (reg_addr == 12'h00C || reg_addr == 12'h01C);
            m_pend = (clr_m ? 11'h0 : m_pend) | hit_m;
            if (reg_wr && reg_addr == 12'h004) m_target = reg_wdata;
            if (reg_wr && reg_addr == 12'h018) m_en = reg_wdata[10:0];
            m_send = (m_send && !msg_ready) || trig_m;
            hq.push_front(irq_lines);
            void'(hq.pop_back());
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            n_chk++;
            if (msg_valid !== m_send ||
                (m_send && (msg_addr !== (m_target & 32'hFFFF_FFE0) ||
                            msg_data !== (m_target & 32'h1F)))) begin
                n_err++;
                $display("FAIL R7/R8 model: valid=%0b addr=%h data=%h exp valid=%0b addr=%h data=%h",
                         msg_valid, msg_addr, msg_data, m_send,
                         m_target & 32'hFFFF_FFE0, m_target & 32'h1F);
            end
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 50000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected<=50000 cycles", wd);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(logic [11:0] a, logic [31:0] exp, string tag);
        reg_rd = 1'b1; reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; irq_lines = '0; reg_wr = 0; reg_rd = 0;
        reg_addr = '0; reg_wdata = '0; msg_ready = 1'b1;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        check("R1 msg_valid", {31'b0, msg_valid}, 32'h0);
        rd_chk(12'h018, 32'h0, "R1 enable");
        rd_chk(12'h004, 32'h0, "R1 target");
        rd_chk(12'h024, 32'h0, "R1 control");
        rd_chk(12'h00C, 32'h0, "R1 pending");

        // R11: read-back
        wr(12'h004, 32'hF123_4567);
        wr(12'h018, 32'hFFFF_F7FF);
        wr(12'h024, 32'h0000_01A5);
        rd_chk(12'h004, 32'hF123_4567, "R11 target");
        rd_chk(12'h018, 32'h0000_07FF, "R11 enable");
        rd_chk(12'h024, 32'h0000_00A5, "R11 control");
        rd_chk(12'h100, 32'h0, "R11 unmapped");

        // R7 / R8: message content, hold, merge
        msg_ready = 1'b0;
        irq_lines[0] = 1'b1;
        idle(5);
        check("R7 valid", {31'b0, msg_valid}, 32'h1);
        check("R7 addr", msg_addr, 32'hF123_4560);
        check("R7 data", msg_data, 32'h0000_0007);
        irq_lines[1] = 1'b1;
        idle(5);
        check("R8 held", {31'b0, msg_valid}, 32'h1);
        msg_ready = 1'b1;
        idle(1);
        check("R8 merged", {31'b0, msg_valid}, 32'h0);

        // R2 level, no side effect; R3 pending
        rd_chk(12'h028, 32'h0000_0003, "R2 level");
        rd_chk(12'h01C, 32'h0000_0003, "R3 R5 pending via status");
        rd_chk(12'h00C, 32'h0, "R5 cleared");
        irq_lines = '0;
        idle(4);

        // R3 disabled line sets nothing
        wr(12'h018, 32'h0000_0001);
        irq_lines[2] = 1'b1;
        idle(5);
        rd_chk(12'h00C, 32'h0, "R3 disabled line");
        rd_chk(12'h028, 32'h0000_0004, "R2 level disabled");
        irq_lines = '0;
        wr(12'h018, 32'h0000_07FF);
        idle(4);

        // R6: line 9
        irq_lines[9] = 1'b1;
        idle(5);
        check("R6 no message", {31'b0, msg_valid}, 32'h0);
        rd_chk(12'h00C, 32'h0, "R6 no pending");
        irq_lines[9] = 1'b0;
        idle(4);

        // R9: high before enable
        wr(12'h018, 32'h0);
        irq_lines[3] = 1'b1;
        idle(5);
        wr(12'h018, 32'h0000_0008);
        idle(5);
        check("R9 no message", {31'b0, msg_valid}, 32'h0);
        rd_chk(12'h00C, 32'h0, "R9 no pending");
        rd_chk(12'h028, 32'h0000_0008, "R9 level visible");
        irq_lines = '0;
        wr(12'h018, 32'h0000_07FF);
        idle(4);

        // R5: status read clears
        irq_lines[4] = 1'b1;
        idle(5);
        rd_chk(12'h01C, 32'h0000_0010, "R5 status value");
        rd_chk(12'h00C, 32'h0, "R5 status cleared");

        // R4: edge on same clock as clearing read survives
        irq_lines[5] = 1'b1;
        idle(2);
        rd_chk(12'h00C, 32'h0, "R4 race read");
        rd_chk(12'h00C, 32'h0000_0020, "R4 race kept");
        rd_chk(12'h00C, 32'h0, "R4 ack cleared");
        irq_lines = '0;
        idle(4);

        // R10: forced message
        wr(12'h00C, 32'h0000_0007);
        check("R10 forced", {31'b0, msg_valid}, 32'h1);
        idle(1);
        wr(12'h00C, 32'h0000_0008);
        check("R10 mismatch ignored", {31'b0, msg_valid}, 32'h0);

        // R8: event in the accept cycle re-arms
        msg_ready = 1'b0;
        wr(12'h00C, 32'h0000_0007);
        msg_ready = 1'b1;
        wr(12'h00C, 32'h0000_0007);
        check("R8 rearm", {31'b0, msg_valid}, 32'h1);
        idle(1);
        check("R8 drained", {31'b0, msg_valid}, 32'h0);

        idle(3);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule